// File: doc/BRIEF.md
# Vector Element Merge, Pack and Unpack Unit

This unit rearranges the elements of 128-bit vectors. Every operation uses a fixed index rule. It covers six operations:

- interleaving the high or low halves of two sources (merge);
- narrowing two sources into one by truncation (pack);
- widening one half of a single source (unpack, zero- or sign-extending);
- sign-extending the rightmost element of each doubleword to 64 bits.

An opcode and an element-size code come in with the two source vectors. Elements are numbered from the left, so element 0 always sits in the most significant bits.

Each operation accepts only some element sizes. A size code outside an operation's legal set raises a specification-exception flag instead of producing a result. In that case the result register keeps its previous contents, and the destination is unchanged. Results appear one cycle after the request, together with an output-valid flag.

Top module: `vmp_unit`

## Requirements
- R1: Opcode 0 (merge high) writes destination element d from source element d/2. Even d reads `src_a` and odd d reads `src_b`. Element 0 is the most significant element. Size codes 0,1,2,3 select 8,16,32,64-bit elements.
- R2: Opcode 1 (merge low) takes source element (d+N)/2, where N is the element count. It keeps the same even/odd choice of source.
- R3: Opcode 2 (pack) treats the size code (1,2,3) as the source element width. It keeps the low half of each source element. The result holds all of `src_a`'s elements first, then all of `src_b`'s.
- R4: Opcodes 3 (signed) and 4 (logical) are unpack high. Destination element d is source element d of `src_a`, at twice the width. Opcode 3 sign-extends it and opcode 4 zero-extends it.
- R5: Opcodes 5 (signed) and 6 (logical) are unpack low. They take source element d + Ns/2, where Ns is the source element count, and extend it in the same way as R4.
- R6: Opcode 7 takes the rightmost element of each 64-bit doubleword of `src_a` and sign-extends it into that doubleword. Size codes 0 to 2 are legal for this opcode.
- R7: A size code outside the opcode's legal set sets `spec_exc` with the result. The legal sets are: merge 0–3; pack 1–3; unpack 0–2; opcode 7 0–2.
- R8: On a specification exception, `result` keeps the value it held before the request.
- R9: `out_valid` is high exactly in the cycle after an accepted request. `spec_exc` is low whenever `out_valid` is low.
- R10: After synchronous reset, `out_valid`, `spec_exc` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| op | input | 3 | Operation code (0–7) |
| esz | input | 3 | Element-size code |
| src_a | input | 128 | First source vector |
| src_b | input | 128 | Second source vector |
| out_valid | output | 1 | Result valid, one cycle after request |
| spec_exc | output | 1 | Illegal size code for the opcode |
| result | output | 128 | Registered destination vector |

## Verification
The bench builds the unit with its default 128-bit vector width. At that width there are two doublewords, so opcode 7 reads element pairs 7/15, 3/7 and 1/3. Merge and pack reach their full element counts, from sixteen bytes down to two doublewords. Every legal size of every opcode is driven with varied data. Each illegal size boundary is also driven: pack with code 0 and code 4, unpack and opcode 7 with code 3, and merge with code 4. These show the exception and the held destination.

// File: rtl/vmp_pkg.sv
package vmp_pkg;

    typedef enum logic [2:0] {
        OP_MRG_HI  = 3'd0,
        OP_MRG_LO  = 3'd1,
        OP_PACK    = 3'd2,
        OP_UNPH_S  = 3'd3,
        OP_UNPH_L  = 3'd4,
        OP_UNPL_S  = 3'd5,
        OP_UNPL_L  = 3'd6,
        OP_SEXT_DW = 3'd7
    } vmp_op_e;

    localparam int ESZ_W     = 3;
    localparam int NUM_SIZES = 4;
    localparam int DW_BITS   = 64;

    typedef struct packed {
        logic vld;
        logic exc;
    } vmp_flags_t;

    function automatic logic size_ok(input vmp_op_e op, input logic [ESZ_W-1:0] esz);
        logic ok;
        case (op)
            OP_MRG_HI, OP_MRG_LO: ok = (esz <= 3'd3);
            OP_PACK:              ok = (esz >= 3'd1) && (esz <= 3'd3);
            OP_SEXT_DW:           ok = (esz <= 3'd2);
            default:              ok = (esz <= 3'd2);
        endcase
        return ok;
    endfunction

    function automatic logic is_unpack_low(input vmp_op_e op);
        return (op == OP_UNPL_S) || (op == OP_UNPL_L);
    endfunction

    function automatic logic is_unpack_signed(input vmp_op_e op);
        return (op == OP_UNPH_S) || (op == OP_UNPL_S);
    endfunction

endpackage

// File: rtl/vmp_merge.sv
module vmp_merge
    import vmp_pkg::*;
#(
    parameter int VB = 128
) (
    input  logic [VB-1:0]    a,
    input  logic [VB-1:0]    b,
    input  logic             lo_half,
    input  logic [ESZ_W-1:0] esz,
    output logic [VB-1:0]    y
);

    for (genvar k = 0; k < NUM_SIZES; k++) begin : g_sz
        localparam int W = 8 << k;
        localparam int N = VB / W;
        logic [VB-1:0] c;
        always_comb begin
            c = '0;
            for (int d = 0; d < N; d++) begin
                if (d % 2 == 0)
                    c[VB-1-d*W -: W] = a[VB-1-(lo_half ? (d+N)/2 : d/2)*W -: W];
                else
                    c[VB-1-d*W -: W] = b[VB-1-(lo_half ? (d+N)/2 : d/2)*W -: W];
            end
        end
    end

    always_comb begin
        case (esz)
            3'd0:    y = g_sz[0].c;
            3'd1:    y = g_sz[1].c;
            3'd2:    y = g_sz[2].c;
            3'd3:    y = g_sz[3].c;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/vmp_pack.sv
module vmp_pack
    import vmp_pkg::*;
#(
    parameter int VB = 128
) (
    input  logic [VB-1:0]    a,
    input  logic [VB-1:0]    b,
    input  logic [ESZ_W-1:0] esz,
    output logic [VB-1:0]    y
);

    for (genvar k = 1; k < NUM_SIZES; k++) begin : g_sz
        localparam int W  = 8 << k;
        localparam int HW = W / 2;
        localparam int N  = VB / W;
        logic [VB-1:0] c;
        always_comb begin
            c = '0;
            for (int d = 0; d < N; d++) begin
                c[VB-1-d*HW -: HW]     = a[VB-1-d*W-HW -: HW];
                c[VB-1-(d+N)*HW -: HW] = b[VB-1-d*W-HW -: HW];
            end
        end
    end

    always_comb begin
        case (esz)
            3'd1:    y = g_sz[1].c;
            3'd2:    y = g_sz[2].c;
            3'd3:    y = g_sz[3].c;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/vmp_unpack.sv
module vmp_unpack
    import vmp_pkg::*;
#(
    parameter int VB = 128
) (
    input  logic [VB-1:0]    a,
    input  logic             lo_half,
    input  logic             sgn,
    input  logic [ESZ_W-1:0] esz,
    output logic [VB-1:0]    y
);

    for (genvar k = 0; k < NUM_SIZES - 1; k++) begin : g_sz
        localparam int W  = 8 << k;
        localparam int DW = 2 * W;
        localparam int ND = VB / DW;
        logic [VB-1:0] c;
        always_comb begin
            c = '0;
            for (int d = 0; d < ND; d++) begin
                c[VB-1-d*DW -: DW] = {
                    {W{sgn & a[VB-1-(lo_half ? d+ND : d)*W]}},
                    a[VB-1-(lo_half ? d+ND : d)*W -: W]
                };
            end
        end
    end

    always_comb begin
        case (esz)
            3'd0:    y = g_sz[0].c;
            3'd1:    y = g_sz[1].c;
            3'd2:    y = g_sz[2].c;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/vmp_sext.sv
module vmp_sext
    import vmp_pkg::*;
#(
    parameter int VB = 128
) (
    input  logic [VB-1:0]    a,
    input  logic [ESZ_W-1:0] esz,
    output logic [VB-1:0]    y
);

    localparam int NDW = VB / DW_BITS;

    for (genvar k = 0; k < NUM_SIZES - 1; k++) begin : g_sz
        localparam int W   = 8 << k;
        localparam int NPD = DW_BITS / W;
        logic [VB-1:0] c;
        always_comb begin
            c = '0;
            for (int j = 0; j < NDW; j++) begin
                c[VB-1-j*DW_BITS -: DW_BITS] = {
                    {(DW_BITS-W){a[VB-1-((j+1)*NPD-1)*W]}},
                    a[VB-1-((j+1)*NPD-1)*W -: W]
                };
            end
        end
    end

    always_comb begin
        case (esz)
            3'd0:    y = g_sz[0].c;
            3'd1:    y = g_sz[1].c;
            3'd2:    y = g_sz[2].c;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/vmp_unit.sv
module vmp_unit
    import vmp_pkg::*;
#(
    parameter int VB = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [2:0]       op,
    input  logic [ESZ_W-1:0] esz,
    input  logic [VB-1:0]    src_a,
    input  logic [VB-1:0]    src_b,
    output logic             out_valid,
    output logic             spec_exc,
    output logic [VB-1:0]    result
);

    vmp_op_e       op_e;
    logic [VB-1:0] y_mrg, y_pck, y_unp, y_sxt, y_sel;
    logic          legal;
    vmp_flags_t    flags_q;
    logic [VB-1:0] res_q;

    assign op_e  = vmp_op_e'(op);
    assign legal = size_ok(op_e, esz);

    vmp_merge #(.VB(VB)) u_merge (
        .a(src_a), .b(src_b), .lo_half(op_e == OP_MRG_LO), .esz(esz), .y(y_mrg)
    );

    vmp_pack #(.VB(VB)) u_pack (
        .a(src_a), .b(src_b), .esz(esz), .y(y_pck)
    );

    vmp_unpack #(.VB(VB)) u_unpack (
        .a(src_a), .lo_half(is_unpack_low(op_e)), .sgn(is_unpack_signed(op_e)),
        .esz(esz), .y(y_unp)
    );

    vmp_sext #(.VB(VB)) u_sext (
        .a(src_a), .esz(esz), .y(y_sxt)
    );

    always_comb begin
        case (op_e)
            OP_MRG_HI, OP_MRG_LO: y_sel = y_mrg;
            OP_PACK:              y_sel = y_pck;
            OP_SEXT_DW:           y_sel = y_sxt;
            default:              y_sel = y_unp;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            res_q   <= '0;
        end else begin
            flags_q.vld <= in_valid;
            flags_q.exc <= in_valid & ~legal;
            if (in_valid && legal)
                res_q <= y_sel;
        end
    end

    assign out_valid = flags_q.vld;
    assign spec_exc  = flags_q.exc;
    assign result    = res_q;

    // R9
    vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R9
    vld_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !spec_exc));

    // R8
    exc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !legal) |=> (spec_exc && $stable(result)));

    // R7
    merge_legal_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (op_e == OP_MRG_HI || op_e == OP_MRG_LO) && esz <= 3'd3) |=> !spec_exc);

    // R9
    exc_needs_vld_chk: assert property (@(posedge clk) disable iff (rst)
        spec_exc |-> out_valid);

endmodule

// File: tb/vmp_unit_test.sv
`timescale 1ns/1ps
module vmp_unit_test;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [2:0]   op;
    logic [2:0]   esz;
    logic [127:0] src_a, src_b;
    logic         out_valid, spec_exc;
    logic [127:0] result;

    int checks = 0;
    int fails  = 0;
    logic [127:0] last_res = '0;
    bit done = 0;

    always #2.5 clk = ~clk;

    vmp_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .esz(esz),
        .src_a(src_a), .src_b(src_b), .out_valid(out_valid),
        .spec_exc(spec_exc), .result(result)
    );

    function automatic logic [127:0] msk(input int w);
        return (w >= 128) ? '1 : ((128'd1 << w) - 128'd1);
    endfunction

    function automatic logic [127:0] fld(input logic [127:0] v, input int w, input int i);
        return (v >> (128 - (i + 1) * w)) & msk(w);
    endfunction

    function automatic logic [127:0] place(input logic [127:0] v, input int w, input int i);
        return (v & msk(w)) << (128 - (i + 1) * w);
    endfunction

    function automatic logic [127:0] sx(input logic [127:0] v, input int w, input int tw);
        if (v[w-1]) return v | (msk(tw) & ~msk(w));
        return v;
    endfunction

    function automatic bit ok(input int o, input int s);
        if (o <= 1) return s <= 3;
        if (o == 2) return (s >= 1) && (s <= 3);
        return s <= 2;
    endfunction

    function automatic logic [127:0] model(input int o, input int s,
                                           input logic [127:0] a, input logic [127:0] b);
        logic [127:0] r = '0;
        int w = 8 << s;
        int n = 128 / w;
        if (o <= 1) begin
            for (int d = 0; d < n; d++) begin
                int si = (o == 0) ? d / 2 : (d + n) / 2;
                r |= place((d % 2) ? fld(b, w, si) : fld(a, w, si), w, d);
            end
        end else if (o == 2) begin
            for (int d = 0; d < 2 * n; d++)
                r |= place((d < n) ? fld(a, w, d) : fld(b, w, d - n), w / 2, d);
        end else if (o <= 6) begin
            for (int d = 0; d < n / 2; d++) begin
                int si = (o >= 5) ? d + n / 2 : d;
                logic [127:0] v = fld(a, w, si);
                if (o == 3 || o == 5) v = sx(v, w, 2 * w);
                r |= place(v, 2 * w, d);
            end
        end else begin
            int per = 64 / w;
            r = place(sx(fld(a, w, per - 1), w, 64), 64, 0) |
                place(sx(fld(a, w, 2 * per - 1), w, 64), 64, 1);
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input int o, input int s, input logic [127:0] a,
                         input logic [127:0] b, input string req);
        logic [127:0] exp;
        @(negedge clk);
        op = 3'(o); esz = 3'(s); src_a = a; src_b = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk({req, " out_valid (R9)"}, 128'(out_valid), 128'd1);
        if (ok(o, s)) begin
            exp = model(o, s, a, b);
            chk({req, " spec_exc (R7)"}, 128'(spec_exc), 128'd0);
            chk(req, result, exp);
            last_res = exp;
        end else begin
            chk({req, " spec_exc (R7)"}, 128'(spec_exc), 128'd1);
            chk({req, " hold (R8)"}, result, last_res);
        end
    endtask

    function automatic logic [127:0] rnd();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic t_reset();
        rst = 1'b1; in_valid = 1'b0; op = '0; esz = '0; src_a = '0; src_b = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R10 out_valid", 128'(out_valid), 128'd0);
        chk("R10 spec_exc", 128'(spec_exc), 128'd0);
        chk("R10 result", result, 128'd0);
    endtask

    task automatic t_merge();
        apply(0, 0, 128'h000102030405060708090A0B0C0D0E0F,
                    128'h101112131415161718191A1B1C1D1E1F, "R1 merge-high bytes");
        chk("R1 merge-high fixed", result, 128'h00100111021203130414051506160717);
        apply(1, 0, 128'h000102030405060708090A0B0C0D0E0F,
                    128'h101112131415161718191A1B1C1D1E1F, "R2 merge-low bytes");
        chk("R2 merge-low fixed", result, 128'h081809190A1A0B1B0C1C0D1D0E1E0F1F);
        for (int s = 0; s < 4; s++)
            for (int i = 0; i < 3; i++) begin
                apply(0, s, rnd(), rnd(), "R1 merge-high");
                apply(1, s, rnd(), rnd(), "R2 merge-low");
            end
    endtask

    task automatic t_pack();
        apply(2, 1, 128'h11AA22BB33CC44DD55EE66FF7700880F,
                    128'h0102030405060708090A0B0C0D0E0F10, "R3 pack 16");
        chk("R3 pack fixed", result, 128'hAABBCCDDEEFF000F020406080A0C0E10);
        for (int s = 1; s < 4; s++)
            for (int i = 0; i < 3; i++) apply(2, s, rnd(), rnd(), "R3 pack");
    endtask

    task automatic t_unpack();
        apply(3, 0, 128'h80017F0000000000_0000000000000000, '0, "R4 unpack-high signed");
        chk("R4 signed fixed", result, 128'hFF800001007F0000_0000000000000000);
        apply(4, 0, 128'h80017F0000000000_0000000000000000, '0, "R4 unpack-high logical");
        chk("R4 logical fixed", result, 128'h00800001007F0000_0000000000000000);
        for (int s = 0; s < 3; s++)
            for (int i = 0; i < 2; i++) begin
                apply(3, s, rnd(), rnd(), "R4 unpack-high signed");
                apply(4, s, rnd(), rnd(), "R4 unpack-high logical");
                apply(5, s, rnd(), rnd(), "R5 unpack-low signed");
                apply(6, s, rnd(), rnd(), "R5 unpack-low logical");
            end
    endtask

    task automatic t_sext();
        apply(7, 0, 128'h00000000000000800000000000000012, '0, "R6 sext bytes");
        chk("R6 sext fixed", result, 128'hFFFFFFFFFFFFFF80_0000000000000012);
        for (int s = 0; s < 3; s++)
            for (int i = 0; i < 3; i++) apply(7, s, rnd(), rnd(), "R6 sext");
    endtask

    task automatic t_exc();
        apply(0, 1, rnd(), rnd(), "R8 setup");
        apply(2, 0, rnd(), rnd(), "R7 pack size 0");
        apply(2, 4, rnd(), rnd(), "R7 pack size 4");
        apply(3, 3, rnd(), rnd(), "R7 unpack size 3");
        apply(6, 3, rnd(), rnd(), "R7 unpack-low size 3");
        apply(7, 3, rnd(), rnd(), "R7 sext size 3");
        apply(1, 4, rnd(), rnd(), "R7 merge size 4");
    endtask

    task automatic t_idle();
        @(negedge clk);
        chk("R9 idle out_valid", 128'(out_valid), 128'd0);
        chk("R9 idle spec_exc", 128'(spec_exc), 128'd0);
        chk("R9 idle result held", result, last_res);
    endtask

    initial begin
        t_reset();
        t_merge();
        t_pack();
        t_unpack();
        t_sext();
        t_exc();
        t_idle();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule